// File: doc/BRIEF.md
# Keypad Lamp Message Decoder

This block sits behind a two-wire bus receiver on a 64-key operator panel. Each key has a left and a right indicator lamp. The receiver hands over complete 8-byte packets. The decoder keeps only well-formed lamp-update packets that are addressed to this panel. From such a packet it stores a two-bit mode for both lamps of the named key. The mode is off, steady on or flashing.

A shared blink divider produces one flashing phase for the whole panel. Its half period is set by a port. The block drives 128 lamp bits in parallel, and a counter records how many packets were rejected.

Packets arrive as one 64-bit word, with byte lane i at bits [8i+7:8i]. The lanes in order are:
- lane 0: destination
- lane 1: source
- lane 2: message code
- lane 3: key index
- lane 4: left-lamp mode
- lane 5: right-lamp mode
- lanes 6 and 7: trailer bytes

Lamp output bit 2k belongs to the left lamp of key k, and bit 2k+1 to its right lamp.

Top module: `lamp_panel_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every lamp mode becomes off, the blink phase becomes 0 and `drop_count` becomes 0. Once reset is released, all `lamp_out` bits read 0.
- R2: A packet is accepted when all of these hold: lane 0 equals `panel_addr`, lane 2 is 55h, lane 3 is at most 3Fh, and lanes 6 and 7 are both EEh. In the clock edge that samples such a packet with `pkt_valid` high, the left mode of key lane 3 is taken from lane 4 and the right mode from lane 5. Both lamps change together.
- R3: A lamp mode is the low two bits of its lane, and the upper six bits are ignored. Code 0 drives the lamp 0, code 1 drives it 1, code 2 makes it follow the blink phase, and code 3 drives it 0.
- R4: A packet whose lane 0 differs from `panel_addr` changes no lamp, and it raises `drop_count` by one.
- R5: A packet whose lane 2 is not 55h changes no lamp, and it raises `drop_count` by one.
- R6: A packet whose key index (lane 3) is 40h or above changes no lamp, and it raises `drop_count` by one.
- R7: A packet in which either lane 6 or lane 7 is not EEh changes no lamp, and it raises `drop_count` by one.
- R8: The source byte (lane 1) has no effect on whether a packet is accepted.
- R9: The blink phase toggles on every N-th clock edge, where N is `blink_half`, or 1 when `blink_half` is 0. All flashing lamps show the same phase. If `blink_half` is lowered below the current count, the phase toggles at the next edge.
- R10: An accepted packet leaves the modes of all other keys unchanged. Packets on consecutive cycles are each applied in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| panel_addr | input | 8 | This panel's bus address (40h..7Fh in use) |
| blink_half | input | 16 | Blink half period in clock cycles (0 is treated as 1) |
| pkt_valid | input | 1 | A complete packet is present on `pkt_data` this cycle |
| pkt_data | input | 64 | Packet bytes; lane i at bits [8i+7:8i] |
| lamp_out | output | 128 | Lamp drive; bit 2k is the left lamp of key k, bit 2k+1 its right lamp |
| drop_count | output | 8 | Number of rejected packets, wrapping |

## Verification
The main function is exercised with accepted packets at the lowest and highest key, with mode bytes whose upper bits are set, and with reserved code 3. Together these separate mode decoding from byte masking and from key indexing. Each rejection rule is tried on its own with every other field valid, so a check that is missing or swapped is visible in the lamp vector and in the drop count. A packet with a foreign source byte and a back-to-back pair of packets show that the source is ignored and that no update is lost. The blink divider is timed at several half periods, including zero, while two flashing lamps on different keys are compared with each other.

// File: rtl/lamp_pkg.sv
// Shared constants and the lamp mode type for the keypad lamp decoder.
// Assumes packets are eight bytes, with byte lane i at bits [8i+7:8i].
package lamp_pkg;
    localparam int BYTE_W    = 8;
    localparam int PKT_BYTES = 8;
    localparam int PKT_W     = BYTE_W * PKT_BYTES;

    // Lane positions are fixed by the packet layout.
    localparam int LANE_DST   = 0;
    localparam int LANE_CODE  = 2;
    localparam int LANE_KEY   = 3;
    localparam int LANE_LEFT  = 4;
    localparam int LANE_RIGHT = 5;
    localparam int LANE_TRL0  = 6;
    localparam int LANE_TRL1  = 7;

    localparam logic [BYTE_W-1:0] LAMP_UPDATE_CODE = 8'h55;
    localparam logic [BYTE_W-1:0] TRAILER_BYTE     = 8'hEE;

    typedef enum logic [1:0] {
        MODE_DARK  = 2'd0,
        MODE_LIT   = 2'd1,
        MODE_BLINK = 2'd2,
        MODE_SPARE = 2'd3
    } lamp_mode_e;

    // Drive level of one lamp, given its mode and the shared blink phase.
    function automatic logic lamp_level(input lamp_mode_e mode, input logic phase);
        case (mode)
            MODE_LIT:   return 1'b1;
            MODE_BLINK: return phase;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/lamp_pkt_check.sv
// Packet qualifier: decides whether a presented packet is a valid lamp
// update for this panel, and extracts the key and both lamp modes.
// Rejected packets are counted in a wrapping counter.
// Assumes each packet is presented for exactly one cycle with pkt_valid.
module lamp_pkt_check
    import lamp_pkg::*;
#(
    parameter  int KEYS  = 64,
    parameter  int CNT_W = 8,
    localparam int KEY_W = $clog2(KEYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       panel_addr,
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt_data,
    output logic             wr_en,
    output logic [KEY_W-1:0] wr_key,
    output logic [1:0]       wr_left,
    output logic [1:0]       wr_right,
    output logic [CNT_W-1:0] drop_count
);
    logic [BYTE_W-1:0] lane_dst, lane_code, lane_key, lane_left, lane_right;
    logic [BYTE_W-1:0] lane_trl0, lane_trl1;
    logic dst_ok, code_ok, key_ok, trl_ok, pkt_ok;
    logic [CNT_W-1:0] drop_q;
    logic unused_lane_bits;

    // Slice the byte lanes that take part in the decision.
    assign lane_dst   = pkt_data[LANE_DST  *BYTE_W +: BYTE_W];
    assign lane_code  = pkt_data[LANE_CODE *BYTE_W +: BYTE_W];
    assign lane_key   = pkt_data[LANE_KEY  *BYTE_W +: BYTE_W];
    assign lane_left  = pkt_data[LANE_LEFT *BYTE_W +: BYTE_W];
    assign lane_right = pkt_data[LANE_RIGHT*BYTE_W +: BYTE_W];
    assign lane_trl0  = pkt_data[LANE_TRL0 *BYTE_W +: BYTE_W];
    assign lane_trl1  = pkt_data[LANE_TRL1 *BYTE_W +: BYTE_W];

    // The source lane and the upper bits of the mode lanes carry no meaning here.
    assign unused_lane_bits = ^{pkt_data[2*BYTE_W-1:BYTE_W],
                                lane_left[BYTE_W-1:2], lane_right[BYTE_W-1:2]};

    // Field qualifiers, one per acceptance rule.
    always_comb begin
        dst_ok  = (lane_dst == panel_addr);
        code_ok = (lane_code == LAMP_UPDATE_CODE);
        key_ok  = (int'(lane_key) < KEYS);
        trl_ok  = (lane_trl0 == TRAILER_BYTE) && (lane_trl1 == TRAILER_BYTE);
        pkt_ok  = dst_ok && code_ok && key_ok && trl_ok;
    end

    // Write request towards the mode store.
    assign wr_en    = pkt_valid && pkt_ok;
    assign wr_key   = lane_key[KEY_W-1:0];
    assign wr_left  = lane_left[1:0];
    assign wr_right = lane_right[1:0];

    // Count every presented packet that is not accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= '0;
        end else if (pkt_valid && !pkt_ok) begin
            drop_q <= drop_q + CNT_W'(1);
        end
    end

    assign drop_count = drop_q;

    // R4
    foreign_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && (lane_dst != panel_addr)) |-> !wr_en);

    // R7
    bad_trailer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && ((lane_trl0 != TRAILER_BYTE) || (lane_trl1 != TRAILER_BYTE))) |-> !wr_en);

    // R6
    key_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(lane_key) < KEYS));

    // R5
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !wr_en) |=> (drop_q == $past(drop_q) + CNT_W'(1)));
endmodule

// File: rtl/lamp_blink_gen.sv
// Free-running blink divider: toggles a single phase bit every N clock
// edges, where N is the programmed half period (0 is treated as 1).
// Assumes the half period may change at any time; a count already past the
// new limit toggles at the next edge.
module lamp_blink_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_period,
    output logic             phase
);
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;
    logic             wrap;

    // Effective half period and terminal-count detection.
    always_comb begin
        limit = (half_period == '0) ? DIV_W'(1) : half_period;
        wrap  = (cnt_q >= limit - DIV_W'(1));
    end

    // Advance the divider and flip the phase at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (wrap) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + DIV_W'(1);
        end
    end

    assign phase = phase_q;

    // R9
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (phase_q != $past(phase_q)) && (cnt_q == '0));

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(phase_q));
endmodule

// File: rtl/lamp_mode_store.sv
// Per-key lamp mode registers and lamp drive. Holds a two-bit mode for the
// left and right lamp of every key. Both lamps of one key are written in the
// same cycle. Lamp 2k is the left lamp of key k and lamp 2k+1 its right lamp.
// Assumes wr_key is in range whenever wr_en is high.
module lamp_mode_store
    import lamp_pkg::*;
#(
    parameter  int KEYS  = 64,
    localparam int KEY_W = $clog2(KEYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [1:0]        wr_left,
    input  logic [1:0]        wr_right,
    input  logic              phase,
    output logic [2*KEYS-1:0] lamp_out
);
    logic [KEYS-1:0][1:0] left_q;
    logic [KEYS-1:0][1:0] right_q;

    // Hold modes; an accepted write replaces both modes of one key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (wr_en) begin
            left_q[wr_key]  <= wr_left;
            right_q[wr_key] <= wr_right;
        end
    end

    // Turn each stored mode into a lamp drive level.
    for (genvar k = 0; k < KEYS; k++) begin : g_key
        assign lamp_out[2*k]   = lamp_level(lamp_mode_e'(left_q[k]),  phase);
        assign lamp_out[2*k+1] = lamp_level(lamp_mode_e'(right_q[k]), phase);
    end

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (left_q[$past(wr_key)] == $past(wr_left)) &&
                  (right_q[$past(wr_key)] == $past(wr_right)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(left_q) && $stable(right_q));
endmodule

// File: rtl/lamp_panel_decoder.sv
// Keypad lamp message decoder, top level. Qualifies incoming lamp-update
// packets, stores per-lamp modes and drives the lamps from a shared blink
// phase. Assumes complete packets arrive from an upstream bus receiver.
module lamp_panel_decoder
    import lamp_pkg::*;
#(
    parameter  int KEYS  = 64,
    parameter  int DIV_W = 16,
    parameter  int CNT_W = 8,
    localparam int KEY_W = $clog2(KEYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        panel_addr,
    input  logic [DIV_W-1:0]  blink_half,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_data,
    output logic [2*KEYS-1:0] lamp_out,
    output logic [CNT_W-1:0]  drop_count
);
    logic             wr_en;
    logic [KEY_W-1:0] wr_key;
    logic [1:0]       wr_left;
    logic [1:0]       wr_right;
    logic             phase;

    // Decide on each packet and produce the write request.
    lamp_pkt_check #(.KEYS(KEYS), .CNT_W(CNT_W)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .panel_addr (panel_addr),
        .pkt_valid  (pkt_valid),
        .pkt_data   (pkt_data),
        .wr_en      (wr_en),
        .wr_key     (wr_key),
        .wr_left    (wr_left),
        .wr_right   (wr_right),
        .drop_count (drop_count)
    );

    // Shared flashing phase.
    lamp_blink_gen #(.DIV_W(DIV_W)) u_blink (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_period (blink_half),
        .phase       (phase)
    );

    // Mode registers and lamp drive.
    lamp_mode_store #(.KEYS(KEYS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_key   (wr_key),
        .wr_left  (wr_left),
        .wr_right (wr_right),
        .phase    (phase),
        .lamp_out (lamp_out)
    );
endmodule

// File: tb/lamp_panel_decoder_test.sv
// Scoreboard bench: the driver computes the expected lamp modes and drop
// count from the requirements and queues them; a monitor compares the
// queued items against the outputs one cycle after each packet.
module lamp_panel_decoder_test;
    localparam logic [7:0] PANEL = 8'h4B;

    typedef struct {
        int           due;
        string        req;
        logic [255:0] snap;
        int           drops;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    panel_addr = PANEL;
    logic [15:0]   blink_half = 16'd5;
    logic          pkt_valid = 1'b0;
    logic [63:0]   pkt_data = '0;
    logic [127:0]  lamp_out;
    logic [7:0]    drop_count;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int mcnt = 0;
    bit mph = 1'b0;
    logic [255:0] mdl = '0;
    int mdl_drops = 0;
    item_t q[$];

    lamp_panel_decoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .panel_addr (panel_addr),
        .blink_half (blink_half),
        .pkt_valid  (pkt_valid),
        .pkt_data   (pkt_data),
        .lamp_out   (lamp_out),
        .drop_count (drop_count)
    );

    always #5 clk = ~clk;

    function automatic int eff_half(input logic [15:0] h);
        return (h == 16'd0) ? 1 : int'(h);
    endfunction

    // Cycle count and blink phase model taken from R9.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mcnt <= 0;
            mph  <= 1'b0;
        end else if (mcnt >= eff_half(blink_half) - 1) begin
            mcnt <= 0;
            mph  <= ~mph;
        end else begin
            mcnt <= mcnt + 1;
        end
    end

    function automatic logic [63:0] mk(input logic [7:0] d, s, c, k, l, r, t0, t1);
        return {t1, t0, r, l, k, c, s, d};
    endfunction

    // Lamp drive expected from R3: code 1 lit, code 2 follows the phase, else dark.
    function automatic logic [127:0] expect_lamps(input logic [255:0] snap, input bit ph);
        logic [127:0] e;
        for (int j = 0; j < 128; j++) begin
            e[j] = (snap[2*j +: 2] == 2'd1) || ((snap[2*j +: 2] == 2'd2) && ph);
        end
        return e;
    endfunction

    task automatic send(input logic [7:0] d, s, c, k, l, r, t0, t1, input string req);
        item_t it;
        bit ok;
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_data  = mk(d, s, c, k, l, r, t0, t1);
        ok = (d == PANEL) && (c == 8'h55) && (k < 8'h40) && (t0 == 8'hEE) && (t1 == 8'hEE);
        if (ok) begin
            mdl[4*int'(k) +: 2]     = l[1:0];
            mdl[4*int'(k) + 2 +: 2] = r[1:0];
        end else begin
            mdl_drops++;
        end
        it.due   = cyc + 1;
        it.req   = req;
        it.snap  = mdl;
        it.drops = mdl_drops;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        pkt_valid = 1'b0;
        pkt_data  = '0;
    endtask

    // Monitor: compare each queued expectation once its apply edge has passed.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [127:0] e;
                it = q.pop_front();
                e = expect_lamps(it.snap, mph);
                checks++;
                if (lamp_out !== e || drop_count !== it.drops[7:0]) begin
                    fails++;
                    $display("FAIL %s: lamp_out=%h drops=%0d expected lamp_out=%h drops=%0d",
                             it.req, lamp_out, drop_count, e, it.drops[7:0]);
                end
            end
        end
    end

    // Time the gaps between transitions of a flashing lamp (R9).
    task automatic measure(input int n, input string req);
        logic prev;
        int last;
        int seen;
        prev = lamp_out[1];
        last = 0;
        seen = 0;
        for (int t = 1; t <= 20 * n + 40 && seen < 4; t++) begin
            @(negedge clk);
            if (lamp_out[1] !== prev) begin
                prev = lamp_out[1];
                if (seen > 0) begin
                    checks++;
                    if (t - last != n) begin
                        fails++;
                        $display("FAIL %s: blink gap=%0d expected %0d", req, t - last, n);
                    end
                end
                last = t;
                seen++;
            end
        end
        checks++;
        if (seen < 4) begin
            fails++;
            $display("FAIL %s: transitions=%0d expected 4", req, seen);
        end
        checks++;
        if (lamp_out[1] !== lamp_out[126]) begin
            fails++;
            $display("FAIL %s: key63 left=%b expected key0 right=%b", req, lamp_out[126], lamp_out[1]);
        end
    endtask

    task automatic check_reset(input string tag);
        checks++;
        if (lamp_out !== '0) begin
            fails++;
            $display("FAIL R1 %s: lamp_out=%h expected 0", tag, lamp_out);
        end
        checks++;
        if (drop_count !== 8'd0) begin
            fails++;
            $display("FAIL R1 %s: drop_count=%0d expected 0", tag, drop_count);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("after power-up");

        send(PANEL, 8'h01, 8'h55, 8'h00, 8'h01, 8'h02, 8'hEE, 8'hEE, "R2 key0 lit/flash");
        send(PANEL, 8'h01, 8'h55, 8'h3F, 8'h02, 8'h00, 8'hEE, 8'hEE, "R2 key63 flash/dark");
        send(PANEL, 8'h01, 8'h55, 8'h05, 8'hFD, 8'h03, 8'hEE, 8'hEE, "R3 upper bits masked, code 3");
        send(PANEL, 8'h01, 8'h55, 8'h05, 8'h03, 8'h41, 8'hEE, 8'hEE, "R3 code 3 dark, masked lit");
        send(8'h4C,  8'h01, 8'h55, 8'h07, 8'h01, 8'h01, 8'hEE, 8'hEE, "R4 foreign destination");
        send(PANEL, 8'h01, 8'h56, 8'h07, 8'h01, 8'h01, 8'hEE, 8'hEE, "R5 wrong code");
        send(PANEL, 8'h01, 8'h55, 8'h40, 8'h01, 8'h01, 8'hEE, 8'hEE, "R6 key 40h");
        send(PANEL, 8'h01, 8'h55, 8'hFF, 8'h01, 8'h01, 8'hEE, 8'hEE, "R6 key FFh");
        send(PANEL, 8'h01, 8'h55, 8'h07, 8'h01, 8'h01, 8'hEF, 8'hEE, "R7 first trailer");
        send(PANEL, 8'h01, 8'h55, 8'h07, 8'h01, 8'h01, 8'hEE, 8'h00, "R7 second trailer");
        send(PANEL, 8'h7A, 8'h55, 8'h0A, 8'h01, 8'h01, 8'hEE, 8'hEE, "R8 foreign source");
        send(PANEL, 8'h01, 8'h55, 8'h0A, 8'h00, 8'h02, 8'hEE, 8'hEE, "R10 back-to-back first");
        send(PANEL, 8'h01, 8'h55, 8'h0B, 8'h01, 8'h00, 8'hEE, 8'hEE, "R10 back-to-back second");
        idle();
        repeat (7) begin
            idle();
        end
        send(PANEL, 8'h01, 8'h55, 8'h00, 8'h01, 8'h02, 8'hEE, 8'hEE, "R2 rewrite key0");
        idle();
        repeat (3) idle();

        blink_half = 16'd3;
        measure(3, "R9 half period 3");
        blink_half = 16'd0;
        measure(1, "R9 half period 0");
        blink_half = 16'd7;
        measure(7, "R9 half period 7");

        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl = '0;
        mdl_drops = 0;
        @(negedge clk);
        check_reset("after mid-run reset");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule